// File: doc/BRIEF.md
# Continuous ADC Sampling Controller with Four-Sample Averaging

This block keeps an external 8-bit analogue-to-digital converter busy without any per-conversion trigger. Once reset is released it repeatedly reads a 3-bit channel code from its input pins, hands that code to the converter, issues a one-cycle start pulse and waits for the converter's done pulse, which carries the 8-bit result. Because the channel code is captured again before every conversion, the selected input can be changed while the block runs, with no reset.

A mode pin chooses what appears on the 8-bit parallel output. With the pin low every conversion result is presented as it arrives. With the pin high four successive results are summed and their truncated mean is presented. A data-valid strobe goes high when a new value is placed on the output and stays high while that value is held. It falls for at least one clock before the output value changes, so a consumer can latch the output on any cycle where the strobe is high.

Top module: `adc_avg_sampler`

## Requirements
- R1: After reset is released, conversions start and repeat with no external trigger; each start request (`adcStart`) is high for exactly one clock, and the next request comes only after the done pulse of the previous one.
- R2: The channel code is presented on `adcChan` bit for bit (bit 0 to bit 0, through bit 2), and `adcChan` holds steady from the start request until that conversion's done pulse.
- R3: `chanSel` is captured again before every conversion, so a new code applied between conversions is used for the next one without a reset.
- R4: With `avgMode` = 0, every conversion result appears on `dataOut` unchanged.
- R5: With `avgMode` = 1, `dataOut` shows the mean of four consecutive results, formed as a 10-bit sum shifted right by two (fraction discarded); for example 255, 255, 255, 254 give 254.
- R6: `dataValid` rises when a new value is placed on `dataOut`, and `dataOut` does not change while `dataValid` stays high.
- R7: `dataValid` is low for at least one clock before `dataOut` takes a new value.
- R8: When `avgMode` differs from the mode of the group being built, the partial group is discarded and a fresh group of four starts with the next conversion.
- R9: While `rstN` is low, `dataOut` is 0, `dataValid` is 0 and `adcStart` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanSel | input | 3 | Channel code read before each conversion |
| avgMode | input | 1 | 0 = raw results, 1 = four-sample mean |
| adcStart | output | 1 | One-cycle conversion start request |
| adcChan | output | 3 | Channel code held for the running conversion |
| adcDone | input | 1 | One-cycle pulse marking a finished conversion |
| adcData | input | 8 | Conversion result, valid with `adcDone` |
| dataOut | output | 8 | Presented result |
| dataValid | output | 1 | High while `dataOut` holds a stable new value |

## Verification
The bench builds the block with its default parameters: an 8-bit sample, a 3-bit channel code and a group of four (shift of two). With those values the 10-bit sum can reach its top value of 1020, so an all-ones group and a group that needs truncation (255, 255, 255, 254) are both in reach, and all eight channel codes can be swept one per conversion. A converter model with a fixed three-cycle latency returns chosen values, which lets the bench place a mode change after two samples of a group and predict the discarded group.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic sample;   // capture channel code and mode pin
    logic accept;   // converter result present this cycle
    logic commit;   // place the pending result on the output
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    S_SAMPLE = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_DROP   = 2'd3
  } seqState_t;

endpackage

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        adcDone,
  input  logic        needPublish,
  output logic        adcStart,
  output ctlStrobes_t strobes
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_SAMPLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_SAMPLE: stateNext = S_LAUNCH;
      S_LAUNCH: stateNext = S_WAIT;
      S_WAIT:   if (adcDone) stateNext = needPublish ? S_DROP : S_SAMPLE;
      S_DROP:   stateNext = S_SAMPLE;
      default:  stateNext = S_SAMPLE;
    endcase
  end

  assign adcStart       = (state == S_LAUNCH);
  assign strobes.sample = (state == S_SAMPLE);
  assign strobes.accept = (state == S_WAIT) && adcDone;
  assign strobes.commit = (state == S_DROP);

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R1
  start_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !adcDone) |=> !adcStart);

endmodule

// File: rtl/adc_avg_dpath.sv
module adc_avg_dpath
  import adc_avg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHAN_W   = 3,
  parameter int AVG_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              avgMode,
  input  logic [DATA_W-1:0] adcData,
  output logic [CHAN_W-1:0] adcChan,
  output logic              needPublish,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SUM_W = DATA_W + AVG_LOG2;
  localparam int CNT_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

  logic [CHAN_W-1:0] chanReg;
  logic              groupMode;
  logic [CNT_W-1:0]  cnt;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  total;
  logic [DATA_W-1:0] pending;
  logic              groupLast;

  assign total       = sum + SUM_W'(adcData);
  assign groupLast   = (cnt == CNT_W'(AVG_N - 1));
  assign needPublish = !groupMode || groupLast;
  assign adcChan     = chanReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg   <= '0;
      groupMode <= 1'b0;
      cnt       <= '0;
      sum       <= '0;
      pending   <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (strobes.sample) begin
        chanReg <= chanSel;
        if (avgMode != groupMode) begin
          groupMode <= avgMode;
          cnt       <= '0;
          sum       <= '0;
        end
      end
      if (strobes.accept) begin
        if (!groupMode) begin
          pending   <= adcData;
          dataValid <= 1'b0;
        end else if (groupLast) begin
          pending   <= DATA_W'(total >> AVG_LOG2);
          sum       <= '0;
          cnt       <= '0;
          dataValid <= 1'b0;
        end else begin
          sum <= total;
          cnt <= cnt + 1'b1;
        end
      end
      if (strobes.commit) begin
        dataOut   <= pending;
        dataValid <= 1'b1;
      end
    end
  end

  // R6
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && $past(dataValid)) |-> $stable(dataOut));

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> !$past(dataValid));

  // R8
  group_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sample && (avgMode != groupMode)) |=> (cnt == '0));

  // R5
  group_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && groupMode && groupLast) |=> (cnt == '0 && !dataValid));

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sample |=> $stable(adcChan));

endmodule

// File: rtl/adc_avg_sampler.sv
module adc_avg_sampler
  import adc_avg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHAN_W   = 3,
  parameter int AVG_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              avgMode,
  output logic              adcStart,
  output logic [CHAN_W-1:0] adcChan,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  ctlStrobes_t strobes;
  logic        needPublish;

  adc_avg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .adcDone    (adcDone),
    .needPublish(needPublish),
    .adcStart   (adcStart),
    .strobes    (strobes)
  );

  adc_avg_dpath #(
    .DATA_W  (DATA_W),
    .CHAN_W  (CHAN_W),
    .AVG_LOG2(AVG_LOG2)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .chanSel    (chanSel),
    .avgMode    (avgMode),
    .adcData    (adcData),
    .adcChan    (adcChan),
    .needPublish(needPublish),
    .dataOut    (dataOut),
    .dataValid  (dataValid)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!dataValid && !adcStart && dataOut == '0));

endmodule

// File: tb/tb_adc_avg_sampler.sv
module tb_adc_avg_sampler;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] chanSel = 3'd0;
  logic       avgMode = 1'b0;
  logic       adcStart;
  logic [2:0] adcChan;
  logic       adcDone = 1'b0;
  logic [7:0] adcData = 8'd0;
  logic [7:0] dataOut;
  logic       dataValid;

  int checks = 0;
  int fails  = 0;
  int startCount = 0;
  int pubCount = 0;
  int convIdx = 0;
  logic [7:0] lastPub = 8'd0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  bit         expModeQ[$];
  logic [7:0] forceQ[$];

  bit         refMode = 1'b0;
  int         refCnt = 0;
  int         refSum = 0;

  event doneEv;

  always #5 clk = ~clk;

  adc_avg_sampler dut (
    .clk(clk), .rstN(rstN), .chanSel(chanSel), .avgMode(avgMode),
    .adcStart(adcStart), .adcChan(adcChan), .adcDone(adcDone),
    .adcData(adcData), .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Converter model and reference for the expected outputs
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && adcStart) begin
        logic [2:0] seenChan;
        bit         seenMode;
        logic [7:0] d;
        startCount++;
        // R2 R3: code on adcChan matches the pins applied before this conversion
        check(adcChan == chanSel, "R3", adcChan, chanSel);
        seenChan = adcChan;
        seenMode = avgMode;
        repeat (LAT) begin
          @(negedge clk);
          // R1: no second request while this one is outstanding
          if (adcStart) check(1'b0, "R1", 1, 0);
        end
        // R2: channel held until done
        check(adcChan == seenChan, "R2", adcChan, seenChan);
        if (forceQ.size() > 0) d = forceQ.pop_front();
        else d = 8'((convIdx * 53) + (seenChan * 17) + 7);
        convIdx++;
        if (seenMode != refMode) begin
          refMode = seenMode;
          refCnt  = 0;
          refSum  = 0;
        end
        if (!seenMode) begin
          expQ.push_back(d);
          expModeQ.push_back(1'b0);
        end else begin
          refSum += d;
          refCnt++;
          if (refCnt == 4) begin
            expQ.push_back(8'(refSum >> 2));
            expModeQ.push_back(1'b1);
            refCnt = 0;
            refSum = 0;
          end
        end
        adcDone = 1'b1;
        adcData = d;
        @(negedge clk);
        adcDone = 1'b0;
        adcData = 8'h00;
        ->doneEv;
      end
    end
  end

  // Output monitor
  initial begin
    bit         prevValid = 1'b0;
    logic [7:0] prevOut = 8'd0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (dataValid && !prevValid) begin
          logic [7:0] e;
          bit m;
          if (expQ.size() == 0) begin
            check(1'b0, "R6", dataOut, -1);
          end else begin
            e = expQ.pop_front();
            m = expModeQ.pop_front();
            // R4 raw path, R5 averaged path
            check(dataOut == e, m ? "R5" : "R4", dataOut, e);
          end
          lastPub = dataOut;
          pubCount++;
        end
        if (dataValid && prevValid)
          check(dataOut == prevOut, "R6", dataOut, prevOut);
        if (dataOut != prevOut)
          check(!prevValid, "R7", prevValid, 0);
      end
      prevValid = dataValid;
      prevOut   = dataOut;
    end
  end

  task automatic testReset();
    int s0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R9
    check(dataOut == 8'd0, "R9", dataOut, 0);
    check(dataValid == 1'b0, "R9", dataValid, 0);
    check(adcStart == 1'b0, "R9", adcStart, 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    // R1: a conversion begins unprompted
    check(startCount >= 1, "R1", startCount, 1);
    s0 = startCount;
    repeat (200) @(negedge clk);
    // R1: conversions keep running with nothing driven
    check(startCount - s0 >= 20, "R1", startCount - s0, 20);
  endtask

  task automatic testRawSweep();
    int p0;
    for (int c = 0; c < 8; c++) begin
      @(doneEv);
      chanSel = 3'(c);
      avgMode = 1'b0;
      forceQ.push_back(8'(c * 30 + 1));
    end
    @(doneEv);
    repeat (2) @(negedge clk);
    // R4: last raw sample on channel 7
    check(lastPub == 8'd211, "R4", lastPub, 211);
    p0 = pubCount;
    repeat (60) @(negedge clk);
    // R4: raw mode publishes every conversion
    check(pubCount - p0 >= 5, "R4", pubCount - p0, 5);
  endtask

  task automatic testAvgTrunc();
    logic [7:0] vals[4] = '{8'd255, 8'd255, 8'd255, 8'd254};
    @(doneEv);
    avgMode = 1'b0;
    chanSel = 3'd2;
    for (int i = 0; i < 4; i++) begin
      @(doneEv);
      avgMode = 1'b1;
      forceQ.push_back(vals[i]);
    end
    @(doneEv);
    repeat (2) @(negedge clk);
    // R5: 1019 >> 2 = 254
    check(lastPub == 8'd254, "R5", lastPub, 254);
    for (int i = 0; i < 4; i++) begin
      forceQ.push_back(8'd255);
      @(doneEv);
    end
    repeat (2) @(negedge clk);
    // R5: full-scale group keeps 255 without overflow
    check(lastPub == 8'd255, "R5", lastPub, 255);
  endtask

  task automatic testModeSwitch();
    logic [7:0] vals[7] = '{8'd10, 8'd20, 8'd99, 8'd100, 8'd104, 8'd108, 8'd113};
    bit         modes[7] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    @(doneEv);
    avgMode = 1'b0;
    chanSel = 3'd5;
    for (int i = 0; i < 7; i++) begin
      @(doneEv);
      avgMode = modes[i];
      chanSel = 3'(i);
      forceQ.push_back(vals[i]);
      if (i == 3) begin
        repeat (2) @(negedge clk);
        // R8: the raw sample interrupts the partial group and is shown
        check(lastPub == 8'd99, "R8", lastPub, 99);
      end
    end
    @(doneEv);
    repeat (2) @(negedge clk);
    // R8: fresh group 100,104,108,113 -> 425 >> 2 = 106
    check(lastPub == 8'd106, "R8", lastPub, 106);
  endtask

  initial begin
    testReset();
    testRawSweep();
    testAvgTrunc();
    testModeSwitch();
    repeat (40) @(negedge clk);
    // R6: every published value was accounted for
    check(expQ.size() <= 1, "R6", expQ.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule